// File: doc/BRIEF.md
# Write-Through Direct-Mapped Data Cache

This block is a small read/write data cache that sits in front of a word-addressed main memory and serves the memory-access stage of a pipelined processor. It takes byte addresses, a store value and separate read and write requests. It returns load data and a stall flag that the pipeline ORs with its own hazard stalls to freeze the fetch, decode, execute and memory stages. It holds sixteen words as four direct-mapped lines of four words. Each line carries a valid bit and a tag.

On a load miss the cache fetches the whole four-word block from main memory, one word per cycle, holding the stall flag for exactly four cycles. On the cycle after that the requested word comes out as a hit. Every store goes straight to main memory in the cycle it is presented and never stalls. A store that hits also updates the cached copy. A store that misses leaves the cache untouched (no allocation). Main memory therefore always holds the current value of every word.

Top module: `wt_dcache`

## Requirements
- R1: After reset every line is invalid, so the first load to any address misses.
- R2: A byte address splits as line index = bits 5:4, word in line = bits 3:2, tag = bits 31:6; bits 1:0 select nothing. The main-memory word address is the byte address shifted right by two.
- R3: A load whose line is valid with a matching tag returns the cached word in the same cycle, with `stall` low and `mem_re` low.
- R4: A load that misses holds `stall` high for exactly four consecutive cycles. In the cycle after the last stall cycle, `cpu_rdata` carries the main-memory value of the requested word and `stall` is low.
- R5: During the four miss cycles `mem_re` is high and `mem_addr` steps through the block's word addresses in order: block base plus 0, 1, 2, 3. The whole block is installed, so later loads to any word of it hit.
- R6: Every store drives `mem_we` high in the same cycle, with `mem_addr` = byte address shifted right by two and `mem_wdata` = `cpu_wdata`. A store never raises `stall`.
- R7: A store that hits replaces the cached word, so a following load of that address hits and returns the stored value.
- R8: A store that misses does not allocate. A following load of that address misses and returns the stored value from main memory.
- R9: Two addresses with the same index and different tags evict each other: loading one after the other has been installed misses.
- R10: With neither request asserted, `stall`, `mem_re` and `mem_we` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 32 | Byte address from the memory-access stage |
| cpu_wdata | input | 32 | Store value |
| cpu_rd | input | 1 | Load request |
| cpu_wr | input | 1 | Store request |
| cpu_rdata | output | 32 | Load result, valid when `cpu_rd` is high and `stall` is low |
| stall | output | 1 | Freeze request to the pipeline during a load miss |
| mem_addr | output | 30 | Main-memory word address |
| mem_re | output | 1 | Main-memory read, asserted during a refill |
| mem_we | output | 1 | Main-memory write strobe |
| mem_wdata | output | 32 | Main-memory write value |
| mem_rdata | input | 32 | Main-memory read value for `mem_addr`, combinational |

## Verification
The embedded assertions watch, on every cycle, that the valid bits are cleared right after reset. They also check that the refill counter advances by one per stall cycle, that refill addresses increase by one word, and that a stall can never outlast the final refill word. They further check that the request stays held while stalled and that a freshly filled line hits at once. Whether the right data comes back, whether write hits and write misses differ correctly, whether conflicting tags evict each other and whether main memory ends up exact can only be shown by the bench's scenarios. The bench compares against a reference memory and a reference tag model.

// File: rtl/wtdc_pkg.sv
// Package: shared types for the write-through data cache.
// Assumes a load and a store are never requested in the same cycle;
// if both appear, the store takes precedence.
package wtdc_pkg;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_t;

    // Map the two request lines to one access kind (store wins).
    function automatic acc_kind_t classify(input logic rd, input logic wr);
        if (wr)      return ACC_WRITE;
        else if (rd) return ACC_READ;
        else         return ACC_IDLE;
    endfunction

endpackage

// File: rtl/wtdc_tag_store.sv
// Tag store: one valid bit and one tag per direct-mapped line.
// Compares the presented tag against the selected line to form a hit.
// Assumes set is raised only on the last cycle of a refill.
module wtdc_tag_store #(
    parameter int LINES = 4,
    parameter int TAG_W = 26,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic [TAG_W-1:0] tag,
    input  logic             set,
    output logic             hit
);

    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [LINES];

    // Clear all lines on reset; mark a line valid when its refill completes.
    always_ff @(posedge clk) begin
        if (!rst_n)   valid_q <= '0;
        else if (set) valid_q[idx] <= 1'b1;
    end

    // Record the tag of the block being installed.
    always_ff @(posedge clk) begin
        if (set) tag_q[idx] <= tag;
    end

    assign hit = valid_q[idx] && (tag_q[idx] == tag);

    // R1: no line is valid in the first cycle after reset.
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (valid_q == '0));

    // R5: an installed line stays valid.
    a_r5_fill_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> valid_q[$past(idx)]);

endmodule

// File: rtl/wtdc_data_store.sv
// Data store: LINES x WORDS words, one write port and one read port.
// The read is combinational; the write lands at the rising edge.
// Holds no reset: contents matter only once the tag store marks a line valid.
module wtdc_data_store #(
    parameter int LINES  = 4,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    localparam int IDX_W  = $clog2(LINES),
    localparam int WSEL_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [WSEL_W-1:0] wword,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    input  logic [WSEL_W-1:0] rword,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] line_rd [LINES];

    for (genvar l = 0; l < LINES; l++) begin : g_line
        logic [DATA_W-1:0] words [WORDS];

        // Store the incoming word when this line is the write target.
        always_ff @(posedge clk) begin
            if (we && (widx == IDX_W'(l))) words[wword] <= wdata;
        end

        assign line_rd[l] = words[rword];
    end

    assign rdata = line_rd[ridx];

endmodule

// File: rtl/wtdc_fill_ctrl.sv
// Refill controller: counts the words of a block being fetched after a
// load miss. One word arrives per cycle, so a miss stalls for WORDS cycles.
// Assumes the requester holds its load steady while the stall is high.
// WORDS must be a power of two, at least 2.
module wtdc_fill_ctrl #(
    parameter int WORDS = 4,
    localparam int WSEL_W = $clog2(WORDS),
    localparam logic [WSEL_W-1:0] LAST = WSEL_W'(WORDS - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_req,
    output logic              stall,
    output logic [WSEL_W-1:0] fill_word,
    output logic              fill_last
);

    logic [WSEL_W-1:0] cnt_q;

    // Advance through the block while the miss persists; restart otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt_q <= '0;
        else if (miss_req && !fill_last) cnt_q <= cnt_q + 1'b1;
        else                             cnt_q <= '0;
    end

    assign stall     = miss_req;
    assign fill_word = cnt_q;
    assign fill_last = miss_req && (cnt_q == LAST);

    // R4: each stall cycle short of the last fetches the next word.
    a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_req && !fill_last) |=>
            (!miss_req || (fill_word == WSEL_W'($past(fill_word) + 1'b1))));

endmodule

// File: rtl/wt_dcache.sv
// Write-through, direct-mapped, no-write-allocate data cache.
// LINES lines of WORDS words each. Loads that miss stall while the block
// is fetched one word per cycle. Stores go to main memory in the same cycle
// and update the cache only on a hit.
// Assumes main memory answers a read combinationally and accepts a write at
// the next rising edge, and that the pipeline holds the request while stalled.
module wt_dcache
    import wtdc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LINES  = 4,
    parameter int WORDS  = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [ADDR_W-1:0]                    cpu_addr,
    input  logic [DATA_W-1:0]                    cpu_wdata,
    input  logic                                 cpu_rd,
    input  logic                                 cpu_wr,
    output logic [DATA_W-1:0]                    cpu_rdata,
    output logic                                 stall,
    output logic [ADDR_W-$clog2(DATA_W/8)-1:0]   mem_addr,
    output logic                                 mem_re,
    output logic                                 mem_we,
    output logic [DATA_W-1:0]                    mem_wdata,
    input  logic [DATA_W-1:0]                    mem_rdata
);

    localparam int BOFF_W  = $clog2(DATA_W / 8);
    localparam int WSEL_W  = $clog2(WORDS);
    localparam int IDX_W   = $clog2(LINES);
    localparam int IDX_LSB = BOFF_W + WSEL_W;
    localparam int TAG_LSB = IDX_LSB + IDX_W;
    localparam int TAG_W   = ADDR_W - TAG_LSB;

    logic [IDX_W-1:0]  a_idx;
    logic [WSEL_W-1:0] a_word;
    logic [TAG_W-1:0]  a_tag;
    logic              unused_byte_sel;
    acc_kind_t         acc;
    logic              hit, miss_req, wr_hit;
    logic [WSEL_W-1:0] fill_word;
    logic              fill_last;
    logic              ds_we;
    logic [WSEL_W-1:0] ds_wword;
    logic [DATA_W-1:0] ds_wdata;

    // Address fields.
    assign a_idx           = cpu_addr[TAG_LSB-1:IDX_LSB];
    assign a_word          = cpu_addr[IDX_LSB-1:BOFF_W];
    assign a_tag           = cpu_addr[ADDR_W-1:TAG_LSB];
    assign unused_byte_sel = ^cpu_addr[BOFF_W-1:0];

    assign acc      = classify(cpu_rd, cpu_wr);
    assign miss_req = (acc == ACC_READ) && !hit;
    assign wr_hit   = (acc == ACC_WRITE) && hit;

    wtdc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
        .clk   (clk),
        .rst_n (rst_n),
        .idx   (a_idx),
        .tag   (a_tag),
        .set   (fill_last),
        .hit   (hit)
    );

    wtdc_fill_ctrl #(.WORDS(WORDS)) u_fill (
        .clk       (clk),
        .rst_n     (rst_n),
        .miss_req  (miss_req),
        .stall     (stall),
        .fill_word (fill_word),
        .fill_last (fill_last)
    );

    // Data-store write source: refill word from memory, or store data on a hit.
    always_comb begin
        ds_we    = 1'b0;
        ds_wword = a_word;
        ds_wdata = cpu_wdata;
        if (stall) begin
            ds_we    = 1'b1;
            ds_wword = fill_word;
            ds_wdata = mem_rdata;
        end else if (wr_hit) begin
            ds_we    = 1'b1;
        end
    end

    wtdc_data_store #(.LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W)) u_data (
        .clk   (clk),
        .we    (ds_we),
        .widx  (a_idx),
        .wword (ds_wword),
        .wdata (ds_wdata),
        .ridx  (a_idx),
        .rword (a_word),
        .rdata (cpu_rdata)
    );

    // Main-memory side: refill reads walk the block; stores pass straight through.
    always_comb begin
        mem_re    = stall;
        mem_we    = (acc == ACC_WRITE);
        mem_wdata = cpu_wdata;
        if (stall) mem_addr = {cpu_addr[ADDR_W-1:IDX_LSB], fill_word};
        else       mem_addr = cpu_addr[ADDR_W-1:BOFF_W];
    end

    // R4: once the last refill word is taken, the stall cannot continue.
    a_r4_miss_ends: assert property (@(posedge clk) disable iff (!rst_n)
        fill_last |=> !stall);

    // R4: the pipeline keeps the same load presented throughout a stall.
    a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !fill_last) |=> ($stable(cpu_addr) && cpu_rd));

    // R5: refill addresses climb one word per stall cycle.
    a_r5_refill_order: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !fill_last) |=> (!stall || (mem_addr == $past(mem_addr) + 1'b1)));

    // R3: a held load hits in the cycle right after its block lands.
    a_r3_hit_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
        fill_last |=> (!(cpu_rd && !cpu_wr && $stable(cpu_addr)) || hit));

    // R6: load and store requests never overlap.
    a_r6_rw_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_rd && cpu_wr));

endmodule

// File: tb/wt_dcache_tb.sv
// Bench for wt_dcache: directed corner cases then seeded random loads and
// stores, compared against a reference memory and a reference tag model.
module wt_dcache_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [31:0] cpu_rdata;
    logic        stall;
    logic [29:0] mem_addr;
    logic        mem_re, mem_we;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;

    int total = 0;
    int bad   = 0;

    logic [31:0] mem     [1024];
    logic [31:0] exp_mem [1024];
    logic        rv [4];
    logic [25:0] rt [4];

    always #4 clk = ~clk;   // 125 MHz

    wt_dcache u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata), .stall(stall),
        .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Main memory model: combinational read, write at the rising edge.
    assign mem_rdata = mem[mem_addr[9:0]];
    always @(posedge clk) if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit exp_hit(input logic [31:0] a);
        return rv[a[5:4]] && (rt[a[5:4]] == a[31:6]);
    endfunction

    // Load: counts stall cycles, checks refill addresses, then the data.
    task automatic do_read(input logic [31:0] a, input string req);
        bit h = exp_hit(a);
        int n = 0;
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1; cpu_wr = 1'b0;
        #2;
        if (h) chk(mem_re == 1'b0, "R3 no memory read on hit", 32'(mem_re), 32'd0);
        while (stall && n < 10) begin
            chk(mem_re && mem_addr == {a[31:4], 2'(n)}, "R5 refill address order",
                {2'b0, mem_addr}, {2'b0, a[31:4], 2'(n)});
            n++;
            @(negedge clk); #2;
        end
        chk(n == (h ? 0 : 4), {req, " stall cycles"}, 32'(n), h ? 32'd0 : 32'd4);
        chk(cpu_rdata == exp_mem[a[11:2]], {req, " load data"}, cpu_rdata, exp_mem[a[11:2]]);
        rv[a[5:4]] = 1'b1;
        rt[a[5:4]] = a[31:6];
    endtask

    // Store: checks the same-cycle write-through and that no stall appears.
    task automatic do_write(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_rd = 1'b0; cpu_wr = 1'b1;
        #2;
        chk(mem_we && mem_addr == a[31:2] && mem_wdata == d, "R6 write-through",
            {2'b0, mem_addr}, {2'b0, a[31:2]});
        chk(!stall, "R6 store never stalls", 32'(stall), 32'd0);
        exp_mem[a[11:2]] = d;
    endtask

    task automatic go_idle();
        @(negedge clk);
        cpu_rd = 1'b0; cpu_wr = 1'b0;
        #2;
        chk(!stall && !mem_re && !mem_we, "R10 idle is quiet",
            {29'd0, stall, mem_re, mem_we}, 32'd0);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(8 * 150000);
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd411));
        for (int i = 0; i < 1024; i++) begin
            mem[i]     = 32'hC0DE0000 ^ (32'(i) * 32'h00010003);
            exp_mem[i] = mem[i];
        end
        for (int i = 0; i < 4; i++) begin rv[i] = 1'b0; rt[i] = '0; end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk(!stall && !mem_re && !mem_we, "R10 reset state quiet",
            {29'd0, stall, mem_re, mem_we}, 32'd0);

        do_read(32'h0000_0040, "R1 first load after reset misses");
        do_read(32'h0000_0044, "R5 other word of block hits");
        do_read(32'h0000_0043, "R2 byte bits ignored");
        do_read(32'h0000_0050, "R4 miss in line 1");
        do_write(32'h0000_0048, 32'hDEAD_BEEF);
        do_read(32'h0000_0048, "R7 store hit reads back");
        do_write(32'h0000_0200, 32'h1234_5678);
        do_read(32'h0000_0200, "R8 store miss not allocated");
        do_read(32'h0000_0040, "R9 conflict eviction");
        go_idle();

        for (int k = 0; k < 400; k++) begin
            logic [31:0] r = $urandom;
            logic [31:0] d = $urandom;
            if (r[31:30] == 2'b00) do_write({23'd0, r[8:2], 2'b00}, d);
            else if (r[31:28] == 4'hF) go_idle();
            else do_read({23'd0, r[8:0]}, "R3 R4 random load");
        end
        go_idle();
        @(negedge clk);

        for (int i = 0; i < 1024; i++)
            if (mem[i] !== exp_mem[i]) begin
                chk(1'b0, "R6 final main memory", mem[i], exp_mem[i]);
            end
        chk(1'b1, "R6 final main memory scan", 32'd0, 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule